// File: doc/BRIEF.md
# Isolated I/O Bus Cycle Sequencer

This block accepts one port-access request at a time and carries it out as one or two bus cycles on a 16-bit multiplexed address/data bus in the separate I/O address space. A request names a direction (read or write), a size (byte or word), a 16-bit port address and, for writes, 16 bits of data. The block runs each bus cycle through the states T1, T2, T3, optional wait states, and T4. It reports completion with a one-clock done pulse and, for reads, a result word.

The byte lanes are chosen from address bit 0 together with the active-low byte-high enable. A word at an even address uses both lanes in one cycle. A word at an odd address is split into two byte cycles, and the block puts the bytes back in order on reads. The multiplexed bus is modelled as separate output, output-enable and input vectors. The I/O select output is high for the whole of every cycle this block runs.

Top module: `pio_bus_sequencer`

## Requirements
- R1: After reset the bus is idle. bus_io_sel, bus_ale, bus_ad_oe and rsp_done are 0, and bus_rd_n, bus_wr_n, bus_den_n, bus_dtr_n and bus_bhe_n are 1.
- R2: A start accepted in idle makes the next clock T1. In T1, bus_ale is high for exactly one clock, bus_ad_o carries the port address with bus_ad_oe high, and bus_a_hi is 0. bus_io_sel stays high from T1 through T4 of every bus cycle.
- R3: The lane code is sampled in T1 as (address bit 0, bus_bhe_n). An even byte uses (0,1), an odd byte uses (1,0) and an even word uses (0,0). The code (1,1) never appears.
- R4: In a write cycle, bus_wr_n is low from T2 until the end of the last T3 or wait state, and high in T4. Write data is driven from T2 through T4. An even byte goes on bits 7:0, an odd byte goes on bits 15:8, and an even word uses all 16 bits.
- R5: In a read cycle, bus_rd_n and bus_den_n are low from T2 through the last T3 or wait state, and bus_ad_oe is low from T2 through T4. bus_dtr_n is 0 for the whole of a read cycle and 1 for the whole of a write cycle. bus_rd_n and bus_wr_n are never low together.
- R6: Each clock in T3 or a wait state with bus_ready low adds one wait state, so the strobe stays low for 2 plus the number of wait clocks.
- R7: Read data is taken from bus_ad_i at the T3 or wait-state clock where bus_ready is high. A byte read returns the byte in rsp_rdata bits 7:0 with bits 15:8 zero. An even word read returns bus_ad_i unchanged.
- R8: A word at an odd address runs two cycles. The first cycle uses the given address with code (1,0) and moves the low byte on bits 15:8. The second cycle uses the address plus one with code (0,1) and moves the high byte on bits 7:0. A read returns {second byte, first byte}.
- R9: A word access at address 0xFFFF runs its second cycle at address 0x0000.
- R10: rsp_done is high for exactly one clock, in the clock after the final T4. That is 5 + W clocks after the start edge for a one-cycle transfer and 9 + W for a two-cycle transfer, where W is the total number of wait clocks.
- R11: A start pulse while a transfer is in progress has no effect. The running transfer completes unchanged and no further bus cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start pulse, accepted only when idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | 16 | Port address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_ad_o | output | 16 | Multiplexed address/data, outgoing |
| bus_ad_oe | output | 1 | Output enable for bus_ad_o |
| bus_ad_i | input | 16 | Multiplexed address/data, incoming |
| bus_a_hi | output | 4 | Upper address lines, always 0 |
| bus_bhe_n | output | 1 | Byte-high enable, active low |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_den_n | output | 1 | Data transceiver enable, active low |
| bus_dtr_n | output | 1 | Transceiver direction, 0 = receive |
| bus_io_sel | output | 1 | 1 while an I/O bus cycle runs |
| bus_ready | input | 1 | Low inserts wait states |

## Verification
The assertions assume that bus_ready is a clean, synchronous level and that the request fields are stable in the clock where req_start is sampled. They make no assumption about how long bus_ready stays low. The bench acts as the port device inside a task. It drives bus_ready and bus_ad_i only at falling edges, and it lowers bus_ready only after the strobe has been low for at least one clock, with a bounded number of wait clocks. The request fields change only at falling edges, together with req_start.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PIO_AW = 16;
    localparam int PIO_DW = 16;
    localparam int PIO_HW = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } tstate_e;

    // Per-cycle lane plan for the bus cycle currently running
    typedef struct packed {
        logic [PIO_AW-1:0] addr;
        logic              bhe_n;
        logic [PIO_DW-1:0] wr_lanes;
        logic              cap_full;
        logic              cap_src_hi;
        logic              cap_dst_hi;
    } lane_t;

endpackage

// File: rtl/pio_lane_plan.sv
module pio_lane_plan
    import pio_pkg::*;
#(
    parameter int AW = PIO_AW,
    parameter int DW = PIO_DW
) (
    input  logic [AW-1:0] base_addr,
    input  logic          is_word,
    input  logic [DW-1:0] wdata,
    input  logic          second,
    output logic          two_cycle,
    output lane_t         plan
);
    localparam int LW = DW / 2;

    assign two_cycle = is_word & base_addr[0];

    always_comb begin
        plan      = '0;
        plan.addr = base_addr + AW'(second);
        if (!second) begin
            if (is_word && !base_addr[0]) begin
                // aligned word: both lanes in one cycle
                plan.bhe_n    = 1'b0;
                plan.wr_lanes = wdata;
                plan.cap_full = 1'b1;
            end else if (base_addr[0]) begin
                // odd byte, or first half of a split word: upper lane
                plan.bhe_n      = 1'b0;
                plan.wr_lanes   = {wdata[LW-1:0], {LW{1'b0}}};
                plan.cap_src_hi = 1'b1;
                plan.cap_dst_hi = 1'b0;
            end else begin
                // even byte: lower lane
                plan.bhe_n    = 1'b1;
                plan.wr_lanes = {{LW{1'b0}}, wdata[LW-1:0]};
            end
        end else begin
            // second half of a split word: even address, lower lane
            plan.bhe_n      = 1'b1;
            plan.wr_lanes   = {{LW{1'b0}}, wdata[DW-1:LW]};
            plan.cap_src_hi = 1'b0;
            plan.cap_dst_hi = 1'b1;
        end
    end

endmodule

// File: rtl/pio_tstate_seq.sv
module pio_tstate_seq
    import pio_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    ready,
    input  logic    two_cycle,
    output tstate_e st,
    output logic    second,
    output logic    done,
    output logic    capture,
    output logic    launch
);
    typedef struct packed {
        tstate_e st;
        logic    second;
        logic    done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: if (start) begin
                seq_d.st     = ST_T1;
                seq_d.second = 1'b0;
            end
            ST_T1: seq_d.st = ST_T2;
            ST_T2: seq_d.st = ST_T3;
            ST_T3, ST_TW: seq_d.st = ready ? ST_T4 : ST_TW;
            ST_T4: begin
                if (two_cycle && !seq_q.second) begin
                    seq_d.st     = ST_T1;
                    seq_d.second = 1'b1;
                end else begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, second: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st      = seq_q.st;
    assign second  = seq_q.second;
    assign done    = seq_q.done;
    assign capture = ((seq_q.st == ST_T3) || (seq_q.st == ST_TW)) && ready;
    assign launch  = (seq_q.st == ST_IDLE) && start;

    // Wait state persists while ready stays low
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_TW && !ready) |=> (seq_q.st == ST_TW));

    // Completion pulse lasts one clock
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // Second bus cycle of a split word follows T4 directly
    assert_split_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_T1 && seq_q.second) |-> ($past(seq_q.st) == ST_T4));

endmodule

// File: rtl/pio_bus_sequencer.sv
module pio_bus_sequencer
    import pio_pkg::*;
#(
    parameter int AW = PIO_AW,
    parameter int DW = PIO_DW,
    parameter int HW = PIO_HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic          req_rd,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_ad_oe,
    input  logic [DW-1:0] bus_ad_i,
    output logic [HW-1:0] bus_a_hi,
    output logic          bus_bhe_n,
    output logic          bus_ale,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic          bus_den_n,
    output logic          bus_dtr_n,
    output logic          bus_io_sel,
    input  logic          bus_ready
);
    localparam int LW = DW / 2;

    typedef struct packed {
        logic          rd;
        logic          word;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } req_t;

    req_t    req_d, req_q;
    tstate_e seq_st;
    logic    seq_second, seq_done, seq_capture, seq_launch;
    logic    two_cycle;
    lane_t   plan;
    logic [LW-1:0] cap_byte;
    logic    in_cycle, strobe;

    pio_lane_plan #(.AW(AW), .DW(DW)) plan_i (
        .base_addr (req_q.addr),
        .is_word   (req_q.word),
        .wdata     (req_q.wdata),
        .second    (seq_second),
        .two_cycle (two_cycle),
        .plan      (plan)
    );

    pio_tstate_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_start),
        .ready     (bus_ready),
        .two_cycle (two_cycle),
        .st        (seq_st),
        .second    (seq_second),
        .done      (seq_done),
        .capture   (seq_capture),
        .launch    (seq_launch)
    );

    // Request latch and read-result assembly
    always_comb begin
        req_d    = req_q;
        cap_byte = plan.cap_src_hi ? bus_ad_i[DW-1:LW] : bus_ad_i[LW-1:0];
        if (seq_launch) begin
            req_d.rd    = req_rd;
            req_d.word  = req_word;
            req_d.addr  = req_addr;
            req_d.wdata = req_wdata;
            req_d.rdata = '0;
        end else if (seq_capture && req_q.rd) begin
            if (plan.cap_full) begin
                req_d.rdata = bus_ad_i;
            end else if (plan.cap_dst_hi) begin
                req_d.rdata[DW-1:LW] = cap_byte;
            end else begin
                req_d.rdata[LW-1:0] = cap_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    // Bus pin decode from the T-state
    assign in_cycle = (seq_st != ST_IDLE);
    assign strobe   = (seq_st == ST_T2) || (seq_st == ST_T3) || (seq_st == ST_TW);

    assign bus_io_sel = in_cycle;
    assign bus_ale    = (seq_st == ST_T1);
    assign bus_a_hi   = '0;
    assign bus_bhe_n  = in_cycle ? plan.bhe_n : 1'b1;
    assign bus_rd_n   = ~(strobe & req_q.rd);
    assign bus_wr_n   = ~(strobe & ~req_q.rd);
    assign bus_den_n  = ~strobe;
    assign bus_dtr_n  = in_cycle ? ~req_q.rd : 1'b1;
    assign bus_ad_oe  = in_cycle && (bus_ale || !req_q.rd);

    always_comb begin
        bus_ad_o = '0;
        if (seq_st == ST_T1) begin
            bus_ad_o = DW'(plan.addr);
        end else if (in_cycle && !req_q.rd) begin
            bus_ad_o = plan.wr_lanes;
        end
    end

    assign rsp_rdata = req_q.rdata;
    assign rsp_done  = seq_done;

    // ALE lasts one clock, inside an I/O cycle, with the bus driven
    assert_ale_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_io_sel && bus_ad_oe));
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    // The (A0=1, BHE_n=1) lane code is never issued
    assert_lane_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> !(bus_ad_o[0] && bus_bhe_n));

    // Strobes exclusive; reads release the bus and receive
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    assert_read_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (!bus_ad_oe && !bus_dtr_n && !bus_den_n));

    // I/O select drops only as the transfer completes
    assert_io_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_io_sel) |-> rsp_done);

    // A running transfer's request is not overwritten
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st != ST_IDLE) |=> ((seq_st == ST_IDLE) || $stable(req_q.addr)));

endmodule

// File: tb/pio_bus_sequencer_tb_top.sv
module pio_bus_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_start, req_rd, req_word;
    logic [15:0] req_addr, req_wdata;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic [15:0] bus_ad_o, bus_ad_i;
    logic        bus_ad_oe;
    logic [3:0]  bus_a_hi;
    logic        bus_bhe_n, bus_ale, bus_rd_n, bus_wr_n, bus_den_n, bus_dtr_n, bus_io_sel;
    logic        bus_ready;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pio_bus_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_start(req_start), .req_rd(req_rd), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
        .bus_a_hi(bus_a_hi), .bus_bhe_n(bus_bhe_n), .bus_ale(bus_ale),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_den_n(bus_den_n),
        .bus_dtr_n(bus_dtr_n), .bus_io_sel(bus_io_sel), .bus_ready(bus_ready)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Device content: each port address returns a fixed byte
    function automatic logic [7:0] dev_byte(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] exp_read(bit word, logic [15:0] a);
        logic [15:0] a1;
        a1 = a + 16'd1;
        return word ? {dev_byte(a1), dev_byte(a)} : {8'h00, dev_byte(a)};
    endfunction

    task automatic run_xfer(bit rd, bit word, logic [15:0] a, logic [15:0] wd,
                            int waits, bit poke);
        int          k, ncyc, slen, wleft, exp_n, exp_k;
        bit          seen_done, prev_strobe, strobe;
        logic [15:0] cyc_addr [2];
        logic        cyc_bhe  [2];
        logic [15:0] cyc_data [2];
        logic [15:0] cur, ca;
        logic [7:0]  b;
        string       tag;
        k = 0; ncyc = 0; slen = 0; wleft = 0;
        seen_done = 0; prev_strobe = 0;
        cur = '0;
        cyc_addr[0] = '0; cyc_addr[1] = '0;
        cyc_bhe[0] = 1'b0; cyc_bhe[1] = 1'b0;
        cyc_data[0] = '0; cyc_data[1] = '0;
        exp_n = (word && a[0]) ? 2 : 1;
        exp_k = exp_n * (4 + waits) + 1;
        @(negedge clk);
        req_rd = rd; req_word = word; req_addr = a; req_wdata = wd; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        k = 1;
        while (!seen_done && k < 80) begin
            if (bus_ale) begin
                if (ncyc < 2) begin
                    cyc_addr[ncyc] = bus_ad_o;
                    cyc_bhe[ncyc]  = bus_bhe_n;
                end
                cur = bus_ad_o;
                ncyc++;
                slen = 0;
                wleft = waits;
                check(bus_a_hi == 4'h0, "R2", "upper address in T1", bus_a_hi, 0);
                check(bus_io_sel == 1'b1, "R2", "io select in T1", bus_io_sel, 1);
                check(bus_dtr_n == !rd, "R5", "direction in T1", bus_dtr_n, !rd);
            end
            strobe = !bus_rd_n || !bus_wr_n;
            if (strobe) begin
                slen++;
                if (!bus_wr_n && slen == 1 && ncyc >= 1 && ncyc <= 2)
                    cyc_data[ncyc-1] = bus_ad_o;
                if (slen == 1 && rd) begin
                    check(!bus_den_n && !bus_ad_oe && bus_wr_n, "R5", "read enables in T2",
                          {bus_den_n, bus_ad_oe, bus_wr_n}, 3'b001);
                end
                if (slen == 1 && !rd) begin
                    check(bus_ad_oe && bus_rd_n, "R4", "write drive in T2",
                          {bus_ad_oe, bus_rd_n}, 2'b11);
                end
                bus_ad_i = !bus_rd_n ? {dev_byte({cur[15:1], 1'b1}), dev_byte({cur[15:1], 1'b0})} : 16'h0;
                if (slen >= 2 && wleft > 0) begin
                    bus_ready = 1'b0;
                    wleft--;
                end else begin
                    bus_ready = 1'b1;
                end
            end else begin
                bus_ready = 1'b1;
                bus_ad_i  = 16'h0;
                if (prev_strobe) begin
                    check(slen == 2 + waits, "R6", "strobe clocks", slen, 2 + waits);
                    check(bus_io_sel && bus_dtr_n == !rd, "R5", "T4 hold",
                          {bus_io_sel, bus_dtr_n}, {1'b1, !rd});
                    if (!rd) check(bus_ad_oe == 1'b1, "R4", "data held in T4", bus_ad_oe, 1);
                end
            end
            prev_strobe = strobe;
            if (poke && k == 3) begin
                req_start = 1'b1; req_addr = ~a; req_word = !word; req_rd = !rd;
            end else if (poke && k == 4) begin
                req_start = 1'b0;
            end
            if (rsp_done) begin
                seen_done = 1;
                check(k == exp_k, "R10", "done clock", k, exp_k);
            end else begin
                @(negedge clk);
                k++;
            end
        end
        check(seen_done, "R10", "done seen", seen_done, 1);
        tag = (exp_n == 2) ? "R8" : "R2";
        check(ncyc == exp_n, tag, "bus cycle count", ncyc, exp_n);
        check(cyc_addr[0] == a, "R2", "first cycle address", cyc_addr[0], a);
        if (word && !a[0])
            check(cyc_bhe[0] == 1'b0 && a[0] == 1'b0, "R3", "even word code", cyc_bhe[0], 0);
        else if (a[0])
            check(cyc_bhe[0] == 1'b0, "R3", "odd code", cyc_bhe[0], 0);
        else
            check(cyc_bhe[0] == 1'b1, "R3", "even byte code", cyc_bhe[0], 1);
        if (exp_n == 2) begin
            tag = (a == 16'hFFFF) ? "R9" : "R8";
            check(cyc_addr[1] == a + 16'd1, tag, "second cycle address", cyc_addr[1], a + 16'd1);
            check(cyc_bhe[1] == 1'b1, "R8", "second cycle code", cyc_bhe[1], 1);
        end
        if (rd) begin
            tag = (exp_n == 2) ? "R8" : "R7";
            check(rsp_rdata == exp_read(word, a), tag, "read result", rsp_rdata, exp_read(word, a));
        end else begin
            for (int i = 0; i < exp_n && i < 2; i++) begin
                ca = a + 16'(i);
                b  = (i == 0) ? wd[7:0] : wd[15:8];
                tag = (exp_n == 2) ? "R8" : "R4";
                if (word && !a[0])
                    check(cyc_data[i] == wd, tag, "word lanes", cyc_data[i], wd);
                else if (ca[0])
                    check(cyc_data[i][15:8] == b, tag, "upper lane byte", cyc_data[i][15:8], b);
                else
                    check(cyc_data[i][7:0] == b, tag, "lower lane byte", cyc_data[i][7:0], b);
            end
        end
        @(negedge clk);
        check(rsp_done == 1'b0, "R10", "done single clock", rsp_done, 0);
        check(bus_io_sel == 1'b0, "R2", "io select after transfer", bus_io_sel, 0);
        if (poke) begin
            for (int j = 0; j < 6; j++) begin
                check(!bus_ale && !bus_io_sel, "R11", "no cycle after ignored start",
                      {bus_ale, bus_io_sel}, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        rst_n = 1'b0; req_start = 1'b0; req_rd = 1'b0; req_word = 1'b0;
        req_addr = '0; req_wdata = '0; bus_ad_i = '0; bus_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_io_sel && !bus_ale && !bus_ad_oe && !rsp_done, "R1", "idle highs",
              {bus_io_sel, bus_ale, bus_ad_oe, rsp_done}, 0);
        check(bus_rd_n && bus_wr_n && bus_den_n && bus_dtr_n && bus_bhe_n, "R1", "idle lows",
              {bus_rd_n, bus_wr_n, bus_den_n, bus_dtr_n, bus_bhe_n}, 5'h1F);

        // Directed corner cases
        run_xfer(0, 0, 16'h0088, 16'h0034, 0, 0);   // even byte write
        run_xfer(0, 0, 16'h0089, 16'h00A7, 0, 0);   // odd byte write
        run_xfer(0, 1, 16'hB000, 16'hC3D2, 1, 0);   // even word write
        run_xfer(0, 1, 16'h1235, 16'h9E71, 0, 0);   // split word write
        run_xfer(1, 0, 16'h00AA, 16'h0000, 0, 0);   // even byte read
        run_xfer(1, 0, 16'h00BB, 16'h0000, 2, 0);   // odd byte read
        run_xfer(1, 1, 16'hEA20, 16'h0000, 0, 0);   // even word read
        run_xfer(1, 1, 16'h0F0F, 16'h0000, 3, 0);   // split word read
        run_xfer(1, 1, 16'hFFFF, 16'h0000, 0, 0);   // wrap read
        run_xfer(0, 1, 16'hFFFF, 16'h5AA5, 1, 0);   // wrap write
        run_xfer(1, 0, 16'h4440, 16'h0000, 5, 0);   // long wait
        run_xfer(1, 1, 16'h2001, 16'h0000, 0, 1);   // start while busy
        run_xfer(0, 0, 16'h3000, 16'h0011, 2, 1);

        // Constrained random traffic
        for (int n = 0; n < 80; n++) begin
            logic [15:0] ra;
            ra = 16'($urandom);
            if (n % 8 == 0) ra[0] = 1'b1;
            run_xfer(bit'($urandom % 2), bit'($urandom % 2), ra, 16'($urandom),
                     int'($urandom % 4), (n % 16 == 5));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule